// File: doc/BRIEF.md
# Descriptor Ring Index Registers with Coalesced Interrupt

This block holds the index state for one channel that moves work through two circular descriptor rings kept in host memory. On the request ring the host produces and the device consumes. On the response ring the device produces and the host consumes. The host sees four 32-bit index registers inside a 4 KB window. Two of them it may write. The device side advances the other two with single-cycle event strobes.

The block also decides when the channel raises its message-signalled interrupt. To keep interrupt traffic low, it fires only when a response lands in a ring that was empty. A completion that carries a force flag also fires, but only while forcing is enabled by configuration. The host is expected to drain the response ring after each interrupt. Draining is done by writing the response head up to the tail, and the next response into the empty ring fires again.

For the logic that fetches and stores descriptors, the block computes the host-memory byte address of two slots: the next request slot to read and the next response slot to write. Both rings share one base address, with the request ring placed first.

Top module: `ring_pair_ptrs`

## Requirements
- R1: After reset all four indices read 0, and `irq`, `req_pending` and `rsp_full` are low.
- R2: Within the 4 KB window (`reg_addr[11:0]`), the registers sit at these byte offsets: 0x0 request head (read-only), 0x4 request tail (read/write), 0x8 response head (read/write), 0xC response tail (read-only). Reads return the index zero-extended to 32 bits. Any other offset reads 0, and a write to it changes nothing.
- R3: Host writes to the request head (0x0) and the response tail (0xC) are ignored.
- R4: A host write stores the written value modulo DEPTH, that is, its low log2(DEPTH) bits.
- R5: `dev_req_consume` advances the request head by one when head differs from tail and is ignored otherwise. `req_pending` is high exactly when head differs from tail.
- R6: `rsp_full` is high when (response tail + 1) mod DEPTH equals the response head. A `dev_rsp_push` while full is refused and leaves the tail unchanged. Otherwise the push advances the tail by one.
- R7: An accepted push into an empty response ring (head equal to tail) makes `irq` high for exactly the next cycle.
- R8: An accepted push into a non-empty response ring raises no interrupt unless forced. A refused push never raises one.
- R9: An accepted push with `dev_rsp_force` high raises `irq` the next cycle when `cfg_force_en` is high. With `cfg_force_en` low the flag has no effect.
- R10: After the host writes the response head equal to the tail, the next accepted push raises `irq` again.
- R11: `req_entry_addr` = `cfg_ring_base` + request head × REQ_ELEM_BYTES. `rsp_entry_addr` = `cfg_ring_base` + DEPTH × REQ_ELEM_BYTES + response tail × RSP_ELEM_BYTES.
- R12: Device-advanced indices wrap from DEPTH-1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wen | input | 1 | Host register write strobe |
| reg_addr | input | 12 | Byte offset within the channel window |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| dev_req_consume | input | 1 | Device consumed one request entry |
| req_pending | output | 1 | Request ring holds unconsumed entries |
| dev_rsp_push | input | 1 | Device inserts one response entry |
| dev_rsp_force | input | 1 | Completion asks for a forced interrupt |
| rsp_full | output | 1 | Response ring full; a push is stalled |
| cfg_force_en | input | 1 | Enables the force flag |
| cfg_ring_base | input | 64 | Host base address of the ring pair |
| req_entry_addr | output | 64 | Address of the request slot at the head |
| rsp_entry_addr | output | 64 | Address of the response slot at the tail |
| irq | output | 1 | One-cycle interrupt request pulse |

## Verification
Assertions check several properties on every cycle. A device index stays put when its advance is refused, whether the request ring is empty or the response ring is full. A host-owned index moves only on a write. A host write to the request head leaves it unchanged. Every interrupt pulse traces back to an accepted push. An unforced push into a non-empty response ring is never followed by a pulse.

Only the scenarios can show the rest. That covers the register map and read values, the modulo reduction of written values, and the wrap at DEPTH. It also covers re-arming after the host drains the ring, the gating of the force flag by its enable, and the computed slot addresses.

// File: rtl/rpp_pkg.sv
// Package: shared register selectors and window layout for the ring pair block.
// Assumes the register window is 4 KB and that the registers are 32-bit words.
package rpp_pkg;
    localparam int WIN_BITS = 12;
    localparam int REG_W    = 32;

    typedef enum logic [1:0] {
        SEL_REQ_HEAD = 2'd0,
        SEL_REQ_TAIL = 2'd1,
        SEL_RSP_HEAD = 2'd2,
        SEL_RSP_TAIL = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/rpp_ring_ptrs.sv
// Module: one ring's index pair. One index is written by the host and the
// other is advanced by device strobes. DEV_IS_PRODUCER picks which end the
// device owns, and that decides whether an advance is gated by empty or by full.
// Assumes DEPTH is a power of two, so wrapping is plain truncation.
module rpp_ring_ptrs #(
    parameter int DEPTH           = 16,
    parameter bit DEV_IS_PRODUCER = 1'b0,
    parameter int IDX_W           = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_wen,
    input  logic [IDX_W-1:0] host_wdata,
    input  logic             dev_adv,
    output logic             dev_accept,
    output logic [IDX_W-1:0] dev_idx,
    output logic [IDX_W-1:0] host_idx,
    output logic             empty,
    output logic             full
);
    logic [IDX_W-1:0] prod_idx;
    logic [IDX_W-1:0] cons_idx;

    // Map the owned ends onto producer and consumer, and gate the device advance.
    generate
        if (DEV_IS_PRODUCER) begin : g_dev_prod
            assign prod_idx   = dev_idx;
            assign cons_idx   = host_idx;
            assign dev_accept = dev_adv && !full;
        end else begin : g_dev_cons
            assign prod_idx   = host_idx;
            assign cons_idx   = dev_idx;
            assign dev_accept = dev_adv && !empty;
        end
    endgenerate

    // Occupancy flags; one slot is kept free so that full and empty differ.
    always_comb begin
        empty = (prod_idx == cons_idx);
        full  = ((prod_idx + IDX_W'(1)) == cons_idx);
    end

    // Device-owned index: steps by one on an accepted advance and wraps.
    always_ff @(posedge clk) begin
        if (!rst_n)          dev_idx <= '0;
        else if (dev_accept) dev_idx <= dev_idx + IDX_W'(1);
    end

    // Host-owned index: loads the written value.
    always_ff @(posedge clk) begin
        if (!rst_n)        host_idx <= '0;
        else if (host_wen) host_idx <= host_wdata;
    end

    // R6 / R5: a refused advance leaves the device index unchanged
    a_r6_refused_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_adv && !dev_accept) |=> $stable(dev_idx));

    // R3 / R2: the host-owned index moves only on a host write
    a_r2_host_idx_write_only: assert property (@(posedge clk) disable iff (!rst_n)
        !host_wen |=> $stable(host_idx));
endmodule

// File: rtl/rpp_irq_gen.sv
// Module: interrupt decision for the response ring. It pulses irq one cycle
// after an accepted push into an empty ring, or after an accepted push whose
// force flag is allowed by configuration.
// Assumes rsp_empty reflects the ring before the push is applied.
module rpp_irq_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic push_acc,
    input  logic rsp_empty,
    input  logic force_flag,
    input  logic force_en,
    output logic irq
);
    logic fire;

    // An edge into non-empty, or an enabled forced completion, requests a pulse.
    always_comb fire = push_acc && (rsp_empty || (force_flag && force_en));

    // Register the request as a single-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= fire;
    end

    // R7: every pulse is caused by an accepted push in the previous cycle
    a_r7_pulse_from_push: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(push_acc));
endmodule

// File: rtl/rpp_addr_calc.sv
// Module: host byte addresses of the next request slot to fetch and the
// next response slot to fill. The request ring occupies the start of the
// shared region and the response ring follows it.
// Assumes the element sizes are constants and that the sums wrap at ADDR_W bits.
module rpp_addr_calc #(
    parameter int DEPTH          = 16,
    parameter int ADDR_W         = 64,
    parameter int REQ_ELEM_BYTES = 64,
    parameter int RSP_ELEM_BYTES = 4,
    parameter int IDX_W          = $clog2(DEPTH)
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [IDX_W-1:0]  req_idx,
    input  logic [IDX_W-1:0]  rsp_idx,
    output logic [ADDR_W-1:0] req_addr,
    output logic [ADDR_W-1:0] rsp_addr
);
    localparam logic [ADDR_W-1:0] RSP_REGION = ADDR_W'(DEPTH * REQ_ELEM_BYTES);
    localparam logic [ADDR_W-1:0] REQ_STRIDE = ADDR_W'(REQ_ELEM_BYTES);
    localparam logic [ADDR_W-1:0] RSP_STRIDE = ADDR_W'(RSP_ELEM_BYTES);

    // Address = region start + index * element size.
    always_comb begin
        req_addr = base + ADDR_W'(req_idx) * REQ_STRIDE;
        rsp_addr = base + RSP_REGION + ADDR_W'(rsp_idx) * RSP_STRIDE;
    end
endmodule

// File: rtl/ring_pair_ptrs.sv
// Module: top of one channel. It decodes the host register window, holds
// the request and response ring indices, raises the coalesced interrupt
// and computes the slot addresses.
// Assumes DEPTH is a power of two no larger than 2**32, and that reads are
// combinational with no side effects.
module ring_pair_ptrs #(
    parameter int DEPTH          = 16,
    parameter int ADDR_W         = 64,
    parameter int REQ_ELEM_BYTES = 64,
    parameter int RSP_ELEM_BYTES = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      reg_wen,
    input  logic [rpp_pkg::WIN_BITS-1:0] reg_addr,
    input  logic [rpp_pkg::REG_W-1:0] reg_wdata,
    output logic [rpp_pkg::REG_W-1:0] reg_rdata,
    input  logic                      dev_req_consume,
    output logic                      req_pending,
    input  logic                      dev_rsp_push,
    input  logic                      dev_rsp_force,
    output logic                      rsp_full,
    input  logic                      cfg_force_en,
    input  logic [ADDR_W-1:0]         cfg_ring_base,
    output logic [ADDR_W-1:0]         req_entry_addr,
    output logic [ADDR_W-1:0]         rsp_entry_addr,
    output logic                      irq
);
    import rpp_pkg::*;

    localparam int IDX_W = $clog2(DEPTH);

    logic             hit;
    reg_sel_e         sel;
    logic             wr_req_tail, wr_rsp_head;
    logic [IDX_W-1:0] req_head, req_tail, rsp_head, rsp_tail;
    logic             req_empty, req_full_unused, req_acc_unused;
    logic             rsp_empty, rsp_push_acc;

    // Decode: word-aligned offsets 0x0..0xC in the window hit a register.
    always_comb begin
        hit         = (reg_addr[WIN_BITS-1:4] == '0) && (reg_addr[1:0] == 2'b00);
        sel         = reg_sel_e'(reg_addr[3:2]);
        wr_req_tail = reg_wen && hit && (sel == SEL_REQ_TAIL);
        wr_rsp_head = reg_wen && hit && (sel == SEL_RSP_HEAD);
    end

    // Read mux: zero-extended index, zero for unmapped offsets.
    always_comb begin
        reg_rdata = '0;
        if (hit) begin
            case (sel)
                SEL_REQ_HEAD: reg_rdata = REG_W'(req_head);
                SEL_REQ_TAIL: reg_rdata = REG_W'(req_tail);
                SEL_RSP_HEAD: reg_rdata = REG_W'(rsp_head);
                default:      reg_rdata = REG_W'(rsp_tail);
            endcase
        end
    end

    // Request ring: host produces at the tail, device consumes at the head.
    rpp_ring_ptrs #(.DEPTH(DEPTH), .DEV_IS_PRODUCER(1'b0)) u_req (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wen   (wr_req_tail),
        .host_wdata (reg_wdata[IDX_W-1:0]),
        .dev_adv    (dev_req_consume),
        .dev_accept (req_acc_unused),
        .dev_idx    (req_head),
        .host_idx   (req_tail),
        .empty      (req_empty),
        .full       (req_full_unused)
    );

    // Response ring: device produces at the tail, host consumes at the head.
    rpp_ring_ptrs #(.DEPTH(DEPTH), .DEV_IS_PRODUCER(1'b1)) u_rsp (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wen   (wr_rsp_head),
        .host_wdata (reg_wdata[IDX_W-1:0]),
        .dev_adv    (dev_rsp_push),
        .dev_accept (rsp_push_acc),
        .dev_idx    (rsp_tail),
        .host_idx   (rsp_head),
        .empty      (rsp_empty),
        .full       (rsp_full)
    );

    // Status output for the fetch logic.
    always_comb req_pending = !req_empty;

    // Coalesced interrupt decision.
    rpp_irq_gen u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_acc   (rsp_push_acc),
        .rsp_empty  (rsp_empty),
        .force_flag (dev_rsp_force),
        .force_en   (cfg_force_en),
        .irq        (irq)
    );

    // Slot address arithmetic.
    rpp_addr_calc #(
        .DEPTH(DEPTH), .ADDR_W(ADDR_W),
        .REQ_ELEM_BYTES(REQ_ELEM_BYTES), .RSP_ELEM_BYTES(RSP_ELEM_BYTES)
    ) u_addr (
        .base     (cfg_ring_base),
        .req_idx  (req_head),
        .rsp_idx  (rsp_tail),
        .req_addr (req_entry_addr),
        .rsp_addr (rsp_entry_addr)
    );

    // R3: a host write to the request head offset does not move it
    a_r3_ro_req_head: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wen && reg_addr == 12'h000 && !dev_req_consume) |=> $stable(req_head));

    // R8: an unforced push into a non-empty response ring raises nothing
    a_r8_no_irq_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_rsp_push && !rsp_full && (rsp_head != rsp_tail)
         && !(dev_rsp_force && cfg_force_en)) |=> !irq);

    // R6: a push into a full ring leaves the tail in place
    a_r6_full_push_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_rsp_push && rsp_full) |=> $stable(rsp_tail));
endmodule

// File: tb/ring_pair_ptrs_tb.sv
// Bench: the driver tasks keep a reference model of the four indices and
// queue the cycle numbers in which an interrupt pulse is expected. A monitor
// process takes those entries off the queue and compares them with irq.
module ring_pair_ptrs_tb;
    localparam int  D    = 16;
    localparam int  REQB = 64;
    localparam int  RSPB = 4;
    localparam time TCLK = 20ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wen = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        dev_req_consume = 1'b0;
    logic        req_pending;
    logic        dev_rsp_push = 1'b0;
    logic        dev_rsp_force = 1'b0;
    logic        rsp_full;
    logic        cfg_force_en = 1'b0;
    logic [63:0] cfg_ring_base = 64'h0000_0010_0000_0000;
    logic [63:0] req_entry_addr, rsp_entry_addr;
    logic        irq;

    int total = 0, passed = 0, cyc = 0;
    int m_rqh = 0, m_rqt = 0, m_rsh = 0, m_rst = 0;
    bit m_fen = 0, done = 0;
    int exp_q[$];

    ring_pair_ptrs #(.DEPTH(D), .ADDR_W(64), .REQ_ELEM_BYTES(REQB), .RSP_ELEM_BYTES(RSPB)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .dev_req_consume(dev_req_consume), .req_pending(req_pending),
        .dev_rsp_push(dev_rsp_push), .dev_rsp_force(dev_rsp_force),
        .rsp_full(rsp_full), .cfg_force_en(cfg_force_en),
        .cfg_ring_base(cfg_ring_base), .req_entry_addr(req_entry_addr),
        .rsp_entry_addr(rsp_entry_addr), .irq(irq)
    );

    always #(TCLK/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (ok) passed++;
        else $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    endtask

    task automatic finish_run();
        done = 1;
        $display("%0d/%0d checks passed", passed, total);
        $finish;
    endtask

    // Monitor: pop an expected pulse when its cycle arrives; any other pulse is spurious.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (exp_q.size() > 0 && exp_q[0] == cyc) begin
                void'(exp_q.pop_front());
                check(irq == 1'b1, "R7 expected irq pulse", irq, 1);
            end else if (irq) begin
                check(1'b0, "R8 spurious irq", irq, 0);
            end
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wen = 1'b0;
        if (a == 12'h004) m_rqt = d % D;
        if (a == 12'h008) m_rsh = d % D;
    endtask

    task automatic rd(input logic [11:0] a, input int exp, input string tag);
        reg_addr = a;
        #1;
        check(reg_rdata == 32'(exp), tag, reg_rdata, exp);
    endtask

    task automatic consume();
        dev_req_consume = 1'b1;
        @(negedge clk);
        dev_req_consume = 1'b0;
        if (m_rqh != m_rqt) m_rqh = (m_rqh + 1) % D;
    endtask

    task automatic push(input bit f);
        bit acc, emp;
        acc = (((m_rst + 1) % D) != m_rsh);
        emp = (m_rst == m_rsh);
        if (acc && (emp || (f && m_fen))) exp_q.push_back(cyc + 1);
        dev_rsp_push = 1'b1; dev_rsp_force = f;
        @(negedge clk);
        dev_rsp_push = 1'b0; dev_rsp_force = 1'b0;
        if (acc) m_rst = (m_rst + 1) % D;
    endtask

    initial begin
        #(TCLK * 150000);
        check(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd(12'h000, 0, "R1 req head at reset");
        rd(12'h004, 0, "R1 req tail at reset");
        rd(12'h008, 0, "R1 rsp head at reset");
        rd(12'h00C, 0, "R1 rsp tail at reset");
        check(irq == 0 && req_pending == 0 && rsp_full == 0, "R1 outputs low at reset",
              {irq, req_pending, rsp_full}, 0);

        // R2: request tail is writable at 0x4; R5: pending follows head != tail
        wr(12'h004, 5);
        rd(12'h004, 5, "R2 req tail readback");
        check(req_pending == 1, "R5 req_pending set", req_pending, 1);

        // R3: writes to the read-only indices are ignored
        wr(12'h000, 9);
        rd(12'h000, 0, "R3 req head ignores write");
        wr(12'h00C, 7);
        rd(12'h00C, 0, "R3 rsp tail ignores write");

        // R4: written value reduced modulo DEPTH
        wr(12'h004, 32'h23);
        rd(12'h004, 3, "R4 req tail modulo depth");

        // R5: consume up to the tail, then one more is ignored
        repeat (3) consume();
        rd(12'h000, m_rqh, "R5 req head after consumes");
        check(req_pending == 0, "R5 req_pending clear", req_pending, 0);
        consume();
        rd(12'h000, 3, "R5 consume on empty ignored");

        // R11: request slot address
        #1;
        check(req_entry_addr == cfg_ring_base + 64'(m_rqh * REQB), "R11 req entry addr",
              req_entry_addr, cfg_ring_base + 64'(m_rqh * REQB));

        // R7, R8, R9: interrupt coalescing and force gating
        push(1'b0);                      // R7 empty -> non-empty
        push(1'b0);                      // R8 non-empty, no pulse
        push(1'b1);                      // R9 force disabled, no pulse
        cfg_force_en = 1'b1; m_fen = 1;
        push(1'b1);                      // R9 forced pulse
        rd(12'h00C, m_rst, "R6 rsp tail after pushes");

        // R10: drain by writing head = tail, then the next push re-arms
        wr(12'h008, 32'(m_rst));
        rd(12'h008, m_rst, "R10 rsp head drained");
        push(1'b0);

        // R6, R12: fill to full with wrap, then a push while full stalls
        cfg_force_en = 1'b0; m_fen = 0;
        for (int i = 0; i < 14; i++) push(1'b0);
        rd(12'h00C, 3, "R12 rsp tail wrapped");
        check(rsp_full == 1, "R6 rsp_full asserted", rsp_full, 1);
        push(1'b0);
        rd(12'h00C, 3, "R6 push while full ignored");
        check(rsp_entry_addr == cfg_ring_base + 64'(D * REQB + m_rst * RSPB), "R11 rsp entry addr",
              rsp_entry_addr, cfg_ring_base + 64'(D * REQB + m_rst * RSPB));

        // R2: unmapped offset reads zero and a write to it changes nothing
        wr(12'h010, 1);
        rd(12'h010, 0, "R2 unmapped offset reads zero");
        rd(12'h004, 3, "R2 unmapped write no effect");

        // R12: request head wraps past DEPTH-1
        wr(12'h004, 2);
        for (int i = 0; i < 15; i++) consume();
        rd(12'h000, 2, "R12 req head wrapped");
        check(m_rqh == 2, "R12 model agrees", m_rqh, 2);

        @(negedge clk);
        check(exp_q.size() == 0, "R7 all expected pulses seen", exp_q.size(), 0);
        finish_run();
    end
endmodule